// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

The block is a 2048 x 8 storage array with two ports, called left and right. The ports work independently of each other. Each port has an active-low chip select, a write strobe (low means write), an active-low output enable, an 11-bit address, a write data bus and a registered read data bus. Either port can read or write any word. A port whose chip select is high does nothing.

The two highest words can also serve as doorbells between the ports. When the right port writes word 0x7FE, the left port's active-low interrupt output goes low. The left port clears it by accessing 0x7FE with chip select and output enable low, whether the access is a read or a write. Word 0x7FF works the same way in the other direction. The bytes held in these two words are ordinary data. A level input, `mbox_en`, switches the doorbell function on or off. While it is low, both interrupts stay deasserted and the two words are plain storage.

The model is clocked. Accesses take effect at the rising clock edge, and read data appears on the output bus after that edge.

Top module: `dpram_mailbox`

## Requirements
- R1: A word written at a clock edge reads back from either port. Read data appears on `*_rdata` one edge after a read, where a read is chip select low, write strobe high and output enable low. If one port reads a word in the same cycle that the other port writes it, the read returns the previous contents.
- R2: While a port's chip select is high, that port writes nothing and its `*_rdata` holds its value.
- R3: With `mbox_en` high, a right-port write to 0x7FE drives `l_irq_n` low at the next edge.
- R4: A left-port access to 0x7FE with chip select and output enable both low releases `l_irq_n` to high at the next edge. The write strobe has no effect on the clear.
- R5: A left-port write to 0x7FF drives `r_irq_n` low. A right-port access to 0x7FF with chip select and output enable both low releases it, and the write strobe has no effect.
- R6: The bytes at 0x7FE and 0x7FF store and read back like any other word, with or without `mbox_en`.
- R7: While `mbox_en` is low, no interrupt asserts. A flag that is already set drops at the first edge that sees `mbox_en` low.
- R8: Reset (`rst_n` low) forces both interrupts high and both read buses to 0.
- R9: If a set and a clear reach the same flag in the same cycle, the flag ends up set.
- R10: An access to a mailbox word with output enable high does not clear that port's flag. Writes to any other address do not affect either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | Enables the doorbell function |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write strobe, low writes |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data, registered |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write strobe, low writes |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data, registered |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The assertions assume that the control inputs are known at every clock edge after reset. They also assume the two ports never write the same word in the same cycle, because the block makes no promise about that case. The bench drives all inputs at the falling edge. Its random phase turns a colliding right-port write into a read, and it keeps random addresses below the mailbox words, so any flag change there would be an error.

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mbox_en,
  input  logic          l_cs_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_cs_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] L_BOX = AW'(DEPTH - 2);
  localparam logic [AW-1:0] R_BOX = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic l_flag, r_flag;

  wire l_wr  = !l_cs_n && !l_we_n;
  wire r_wr  = !r_cs_n && !r_we_n;
  wire l_rd  = !l_cs_n && l_we_n && !l_oe_n;
  wire r_rd  = !r_cs_n && r_we_n && !r_oe_n;
  wire l_set = r_wr && (r_addr == L_BOX);
  wire r_set = l_wr && (l_addr == R_BOX);
  wire l_clr = !l_cs_n && !l_oe_n && (l_addr == L_BOX);
  wire r_clr = !r_cs_n && !r_oe_n && (r_addr == R_BOX);

  always_ff @(posedge clk) begin
    if (l_wr) mem[l_addr] <= l_wdata;
    if (r_wr) mem[r_addr] <= r_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_rd) l_rdata <= mem[l_addr];
      if (r_rd) r_rdata <= mem[r_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_flag <= 1'b0;
      r_flag <= 1'b0;
    end else if (!mbox_en) begin
      l_flag <= 1'b0;
      r_flag <= 1'b0;
    end else begin
      if (l_set) l_flag <= 1'b1;
      else if (l_clr) l_flag <= 1'b0;
      if (r_set) r_flag <= 1'b1;
      else if (r_clr) r_flag <= 1'b0;
    end
  end

  assign l_irq_n = !l_flag;
  assign r_irq_n = !r_flag;

  p_left_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !r_cs_n && !r_we_n && r_addr == L_BOX) |=> !l_irq_n);
  p_right_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && !l_cs_n && !l_we_n && l_addr == R_BOX) |=> !r_irq_n);
  p_left_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_irq_n) |-> $past(!mbox_en || (!l_cs_n && !l_oe_n && l_addr == L_BOX)));
  p_right_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_irq_n) |-> $past(!mbox_en || (!r_cs_n && !r_oe_n && r_addr == R_BOX)));
  p_left_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_irq_n) |-> $past(mbox_en && !r_cs_n && !r_we_n && r_addr == L_BOX));
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> (l_irq_n && r_irq_n));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n && r_cs_n) |=> ($stable(l_rdata) && $stable(r_rdata)));
endmodule

// File: tb/test_dpram_mailbox.sv
module test_dpram_mailbox;
  logic clk = 0, rst_n = 0, mbox_en = 0;
  logic l_cs_n = 1, l_we_n = 1, l_oe_n = 1, r_cs_n = 1, r_we_n = 1, r_oe_n = 1;
  logic [10:0] l_addr = 0, r_addr = 0;
  logic [7:0] l_wdata = 0, r_wdata = 0;
  logic [7:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] sb [2048];

  always #4 clk = ~clk;

  dpram_mailbox i_dpram_mailbox (.*);

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 37 + (a >> 5) + s * 91) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lport(input logic cs, input logic we, input logic oe, input int a, input logic [7:0] d);
    l_cs_n = cs; l_we_n = we; l_oe_n = oe; l_addr = 11'(a); l_wdata = d;
  endtask

  task automatic rport(input logic cs, input logic we, input logic oe, input int a, input logic [7:0] d);
    r_cs_n = cs; r_we_n = we; r_oe_n = oe; r_addr = 11'(a); r_wdata = d;
  endtask

  task automatic tick();
    @(negedge clk);
    lport(1, 1, 1, 0, 0);
    rport(1, 1, 1, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] el, er;
    repeat (3) @(negedge clk);
    chk("R8 l_irq_n", {7'b0, l_irq_n}, 8'd1);
    chk("R8 r_irq_n", {7'b0, r_irq_n}, 8'd1);
    chk("R8 l_rdata", l_rdata, 8'h00);
    chk("R8 r_rdata", r_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int a = 0; a < 2048; a++) begin
      lport(0, 0, 1, a, pat(a, 0)); tick();
    end
    chk("R7 no flag while disabled", {6'b0, l_irq_n, r_irq_n}, 8'd3);
    for (int a = 0; a < 2048; a++) begin
      rport(0, 1, 0, a, 0); tick();
      chk("R1 right reads left sweep", r_rdata, pat(a, 0));
    end
    for (int a = 0; a < 2048; a++) begin
      rport(0, 0, 1, a, pat(a, 1)); tick();
    end
    for (int a = 0; a < 2048; a++) begin
      lport(0, 1, 0, a, 0); tick();
      chk("R1 R6 left reads right sweep", l_rdata, pat(a, 1));
    end

    rport(1, 0, 0, 5, 8'hEE); tick();
    lport(1, 1, 0, 5, 0); tick();
    chk("R2 rdata held with cs high", l_rdata, pat(2047, 1));
    lport(0, 1, 0, 5, 0); tick();
    chk("R2 no write with cs high", l_rdata, pat(5, 1));

    mbox_en = 1;
    rport(0, 0, 1, 12'h7FE, 8'h5A); tick();
    chk("R3 left flag set", {7'b0, l_irq_n}, 8'd0);
    chk("R3 right flag untouched", {7'b0, r_irq_n}, 8'd1);
    lport(0, 1, 1, 12'h7FE, 0); tick();
    chk("R10 oe high keeps flag", {7'b0, l_irq_n}, 8'd0);
    lport(0, 0, 1, 12'h100, 8'h01); rport(0, 0, 1, 12'h101, 8'h02); tick();
    chk("R10 other writes keep flag", {7'b0, l_irq_n}, 8'd0);
    lport(0, 1, 0, 12'h7FE, 0); tick();
    chk("R4 read clears", {7'b0, l_irq_n}, 8'd1);
    chk("R6 mailbox data", l_rdata, 8'h5A);
    rport(0, 0, 1, 12'h7FE, 8'h33); tick();
    chk("R3 set again", {7'b0, l_irq_n}, 8'd0);
    lport(0, 0, 0, 12'h7FE, 8'h44); tick();
    chk("R4 write with oe low clears", {7'b0, l_irq_n}, 8'd1);
    lport(0, 1, 0, 12'h7FE, 0); tick();
    chk("R6 mailbox overwritten", l_rdata, 8'h44);

    lport(0, 0, 1, 12'h7FF, 8'hC3); tick();
    chk("R5 right flag set", {7'b0, r_irq_n}, 8'd0);
    rport(0, 1, 1, 12'h7FF, 0); tick();
    chk("R10 right oe high keeps flag", {7'b0, r_irq_n}, 8'd0);
    rport(0, 1, 0, 12'h7FF, 0); tick();
    chk("R5 right read clears", {7'b0, r_irq_n}, 8'd1);
    chk("R6 right mailbox data", r_rdata, 8'hC3);
    lport(0, 0, 1, 12'h7FF, 8'h11); tick();
    rport(0, 0, 0, 12'h7FF, 8'h22); tick();
    chk("R5 right write clears", {7'b0, r_irq_n}, 8'd1);

    rport(0, 0, 1, 12'h7FE, 8'h77); lport(0, 1, 0, 12'h7FE, 0); tick();
    chk("R9 set beats clear", {7'b0, l_irq_n}, 8'd0);
    chk("R1 read before write", l_rdata, 8'h44);
    lport(0, 1, 0, 12'h7FE, 0); tick();
    chk("R4 cleared after tie", {7'b0, l_irq_n}, 8'd1);
    chk("R6 tie write landed", l_rdata, 8'h77);

    rport(0, 0, 1, 12'h7FE, 8'h78); tick();
    chk("R3 set before disable", {7'b0, l_irq_n}, 8'd0);
    mbox_en = 0; tick();
    chk("R7 disable drops flag", {7'b0, l_irq_n}, 8'd1);
    rport(0, 0, 1, 12'h7FE, 8'h99); lport(0, 0, 1, 12'h7FF, 8'h9A); tick();
    chk("R7 no set while disabled", {6'b0, l_irq_n, r_irq_n}, 8'd3);
    lport(0, 1, 0, 12'h7FE, 0); rport(0, 1, 0, 12'h7FF, 0); tick();
    chk("R7 R6 plain left word", l_rdata, 8'h99);
    chk("R7 R6 plain right word", r_rdata, 8'h9A);

    mbox_en = 1;
    for (int a = 0; a < 2048; a++) sb[a] = pat(a, 1);
    sb[12'h100] = 8'h01; sb[12'h101] = 8'h02; sb[5] = pat(5, 1);
    el = l_rdata; er = r_rdata;
    for (int i = 0; i < 4000; i++) begin
      int la, ra, lop, rop;
      logic [7:0] ld, rd;
      la = $urandom_range(0, 2045); ra = $urandom_range(0, 2045);
      lop = $urandom_range(0, 2); rop = $urandom_range(0, 2);
      ld = 8'($urandom); rd = 8'($urandom);
      if (lop == 1 && rop == 1 && la == ra) rop = 0;
      if (lop == 0) lport(0, 1, 0, la, 0); else if (lop == 1) lport(0, 0, 1, la, ld); else lport(1, 1, 0, la, 0);
      if (rop == 0) rport(0, 1, 0, ra, 0); else if (rop == 1) rport(0, 0, 1, ra, rd); else rport(1, 0, 0, ra, rd);
      if (lop == 0) el = sb[la];
      if (rop == 0) er = sb[ra];
      if (lop == 1) sb[la] = ld;
      if (rop == 1) sb[ra] = rd;
      tick();
      chk("R1 R2 random left", l_rdata, el);
      chk("R1 R2 random right", r_rdata, er);
    end
    chk("R10 no flags in random phase", {6'b0, l_irq_n, r_irq_n}, 8'd3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule